// File: doc/BRIEF.md
# Tiled 2D Address Generator

This block takes one pixel position and turns it into an address in a tiled container address space. The position is given as X and Y coordinates. A 2-bit code gives the pixel format and a 3-bit code gives the view orientation. The generator first checks each coordinate against the range that the format allows. It then applies any mirroring the view asks for, and may swap the roles of X and Y for the transposed views. It forms a linear offset from the result, scales that offset by the pixel size, and places the view code and format code in the top five bits.

A caller presents a request with `req_valid` high. One clock later the response appears: the address, the row stride that applies in the chosen view, and a flag that marks a coordinate out of range. The response registers keep their values while no request is present.

Top module: `tiled_addr_gen`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_invalid`, `rsp_addr` and `rsp_stride` are all zero.
- R2: `rsp_valid` is high exactly one clock after `req_valid` was high, and low otherwise. While `req_valid` is low, the response outputs keep their previous values.
- R3: For an in-range request, `rsp_addr[31:29]` equals the orientation code and `rsp_addr[28:27]` equals the format code.
- R4: Each format code has a pair of shifts (xs, ys): code 0 (8-bit) has (0,0), code 1 (16-bit) has (0,1), code 2 (32-bit) has (1,1), and code 3 (page) has (6,6). The usable X width is 14-xs bits and the usable Y width is 13-ys bits.
- R5: If X or Y is larger than its all-ones mask, `rsp_addr` is 0 and `rsp_invalid` is 1. Otherwise `rsp_invalid` is 0.
- R6: Orientation bit 0 replaces X with X XOR its mask. Orientation bit 1 replaces Y with Y XOR its mask.
- R7: When orientation bit 2 is set, the offset is (X << ybits) + Y. When it is clear, the offset is (Y << xbits) + X.
- R8: The offset is shifted left by xs+ys and placed in `rsp_addr[26:0]`, so in page mode the low 12 address bits are zero.
- R9: `rsp_stride` is 1 << (13+xs) when orientation bit 2 is set, and 1 << (14+ys) when it is clear. It is computed even when the coordinates are out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Marks the request inputs as valid |
| req_fmt | input | 2 | Pixel format code |
| req_orient | input | 3 | View orientation code (bit2 flip, bit1 Y-invert, bit0 X-invert) |
| req_x | input | 16 | X coordinate in pixels |
| req_y | input | 16 | Y coordinate in pixels |
| rsp_valid | output | 1 | Response valid, one clock after the request |
| rsp_addr | output | 32 | Tiled address with view and format tags |
| rsp_stride | output | 32 | Row stride in bytes for the chosen view |
| rsp_invalid | output | 1 | Coordinate out of range |

## Verification
The generator holds no state beyond the response registers. Because of that, a wrong shift table entry, a mirror mask or an orientation decode shows up directly in the address or stride of the next response. That response appears exactly one clock after the request that exposes the fault. A stale capture, such as registers that update without a request, appears as a changed output during an idle cycle. The sweep covers every pair of format and orientation, at coordinates that sit at the mask boundary and just above it, so that off-by-one errors in the range check or the masks show up in the cycle that follows.

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen #(
  parameter int CW_BITS     = 14,
  parameter int CH_BITS     = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_fmt,
  input  logic [2:0]         req_orient,
  input  logic [COORD_W-1:0] req_x,
  input  logic [COORD_W-1:0] req_y,
  output logic               rsp_valid,
  output logic [CW_BITS+CH_BITS+4:0] rsp_addr,
  output logic [CW_BITS+CH_BITS+4:0] rsp_stride,
  output logic               rsp_invalid
);
  localparam int OFF_W    = CW_BITS + CH_BITS;
  localparam int ADDR_W   = OFF_W + 5;
  localparam int PG_ALIGN = SLOT_W_BITS + SLOT_H_BITS;

  logic [5:0]        xs, ys, xb, yb;
  logic [OFF_W-1:0]  x_mask, y_mask, xe, ye, xm, ym, lin, lin_sh;
  logic              out_of_range;
  logic [ADDR_W-1:0] addr_c, stride_c;

  always_comb begin
    case (req_fmt)
      2'd0:    begin xs = 6'd0; ys = 6'd0; end
      2'd1:    begin xs = 6'd0; ys = 6'd1; end
      2'd2:    begin xs = 6'd1; ys = 6'd1; end
      default: begin xs = 6'(SLOT_W_BITS); ys = 6'(SLOT_H_BITS); end
    endcase
  end

  assign xb     = 6'(CW_BITS) - xs;
  assign yb     = 6'(CH_BITS) - ys;
  assign x_mask = (OFF_W'(1) << xb) - OFF_W'(1);
  assign y_mask = (OFF_W'(1) << yb) - OFF_W'(1);
  assign xe     = OFF_W'(req_x);
  assign ye     = OFF_W'(req_y);

  assign out_of_range = (ADDR_W'(req_x) > ADDR_W'(x_mask)) ||
                        (ADDR_W'(req_y) > ADDR_W'(y_mask));

  assign xm = req_orient[0] ? (xe ^ x_mask) : xe;
  assign ym = req_orient[1] ? (ye ^ y_mask) : ye;

  assign lin    = req_orient[2] ? ((xm << yb) + ym) : ((ym << xb) + xm);
  assign lin_sh = lin << (xs + ys);

  assign addr_c   = out_of_range ? '0 : {req_orient, req_fmt, lin_sh};
  assign stride_c = req_orient[2] ? (ADDR_W'(1) << (6'(CH_BITS) + xs))
                                  : (ADDR_W'(1) << (6'(CW_BITS) + ys));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      rsp_stride  <= '0;
      rsp_invalid <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr    <= addr_c;
        rsp_stride  <= stride_c;
        rsp_invalid <= out_of_range;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_addr) && $stable(rsp_stride) && $stable(rsp_invalid)));
  p_tag_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_invalid) |->
      (rsp_addr[ADDR_W-1 -: 3] == $past(req_orient) && rsp_addr[OFF_W+1 -: 2] == $past(req_fmt)));
  p_invalid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_invalid) |-> (rsp_addr == '0));
  p_page_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_invalid && rsp_addr[OFF_W+1 -: 2] == 2'd3) |->
      (rsp_addr[PG_ALIGN-1:0] == '0));
  p_stride_pow2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_stride) == 1));
endmodule

// File: tb/tiled_addr_gen_tb_top.sv
module tiled_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_fmt = '0;
  logic [2:0]  req_orient = '0;
  logic [15:0] req_x = '0, req_y = '0;
  logic        rsp_valid, rsp_invalid;
  logic [31:0] rsp_addr, rsp_stride;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tiled_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fmt(req_fmt),
    .req_orient(req_orient), .req_x(req_x), .req_y(req_y),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_stride(rsp_stride),
    .rsp_invalid(rsp_invalid)
  );

  function automatic longint sh_x(input int f);
    return (f == 0) ? 0 : (f == 1) ? 0 : (f == 2) ? 1 : 6;
  endfunction
  function automatic longint sh_y(input int f);
    return (f == 0) ? 0 : (f == 1) ? 1 : (f == 2) ? 1 : 6;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_one(input int f, input int o, input longint x, input longint y);
    longint xs, ys, xb, yb, xmask, ymask, xm, ym, off, e_addr, e_stride;
    bit e_inv;
    xs = sh_x(f); ys = sh_y(f);
    xb = 14 - xs; yb = 13 - ys;
    xmask = (longint'(1) << xb) - 1;
    ymask = (longint'(1) << yb) - 1;
    e_inv = (x > xmask) || (y > ymask);
    xm = o[0] ? (xmask - x) : x;
    ym = o[1] ? (ymask - y) : y;
    off = o[2] ? (xm * (longint'(1) << yb) + ym) : (ym * (longint'(1) << xb) + xm);
    off = off * (longint'(1) << (xs + ys));
    e_addr = e_inv ? 0 : (longint'(o) * 64'h2000_0000 + longint'(f) * 64'h0800_0000 + off);
    e_stride = o[2] ? (longint'(1) << (13 + xs)) : (longint'(1) << (14 + ys));
    req_valid = 1'b1; req_fmt = 2'(f); req_orient = 3'(o);
    req_x = 16'(x); req_y = 16'(y);
    @(negedge clk);
    check("R2 valid", longint'(rsp_valid), 1);
    check(e_inv ? "R5 invalid" : "R3/R4/R6/R7/R8 addr", longint'(rsp_addr), e_addr);
    check("R5 flag", longint'(rsp_invalid), longint'(e_inv));
    check("R9 stride", longint'(rsp_stride), e_stride);
  endtask

  function automatic longint pick(input longint mask, input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return mask / 3;
      3: return mask - 1;
      4: return mask;
      default: return mask + 1;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", longint'(rsp_valid), 0);
    check("R1 addr", longint'(rsp_addr), 0);
    check("R1 stride", longint'(rsp_stride), 0);
    check("R1 invalid", longint'(rsp_invalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 4; f++)
      for (int o = 0; o < 8; o++)
        for (int kx = 0; kx < 6; kx++)
          for (int ky = 0; ky < 6; ky++)
            run_one(f, o, pick((longint'(1) << (14 - sh_x(f))) - 1, kx),
                          pick((longint'(1) << (13 - sh_y(f))) - 1, ky));
    run_one(3, 5, 100, 50);
    begin
      longint a0, s0;
      a0 = longint'(rsp_addr); s0 = longint'(rsp_stride);
      req_valid = 1'b0; req_fmt = 2'd0; req_orient = 3'd2;
      req_x = 16'hFFFF; req_y = 16'h0003;
      @(negedge clk);
      check("R2 idle valid", longint'(rsp_valid), 0);
      check("R2 idle hold addr", longint'(rsp_addr), a0);
      check("R2 idle hold stride", longint'(rsp_stride), s0);
      check("R2 idle hold flag", longint'(rsp_invalid), 0);
    end
    run_one(0, 0, 16'hFFFF, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule